// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segmented logical address into a physical address. A logical address is a 7-bit segment number plus a 16-bit offset. The unit holds 64 segment descriptors, so one unit covers half of the 128 segment numbers. A second unit, built with the other value of the unit-select parameter, answers for the other half. Each descriptor has three fields:

- a 16-bit base, counted in 256-byte units;
- an 8-bit limit, counted in 256-byte blocks;
- an 8-bit attribute field.

The physical address is the base shifted left by eight, plus the offset. It is 24 bits wide and covers 16 MB.

Software, or a loader outside this block, writes descriptors through a write port. Each lookup carries the segment, the offset, a write flag and a system-mode flag. One clock later the unit returns either a translated address or a fault with a code that names the violation. A segment number that belongs to the other unit produces neither. Segment sizes therefore range from 256 bytes (limit 0) to 64 KB (limit 255).

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor holds base 0, limit 0 and attributes 0, and `pa_valid`, `pa`, `fault` and `fault_kind` are all 0.
- R2: A selected, non-violating request returns `pa_valid`=1 and `pa` = (base × 256 + offset) modulo 2^24 in the cycle after the request is presented. The request is selected when the top bit of `req_seg` equals the unit-select value (0 by default).
- R3: If the upper byte of the offset is greater than the limit field, the request faults with `fault_kind`=1 (limit). An upper byte equal to the limit is allowed.
- R4: Attribute bit 0 marks a segment read-only. A write (`req_write`=1) to such a segment faults with `fault_kind`=2. Reads of it translate normally.
- R5: Attribute bit 1 marks a segment system-only. A normal-mode access (`req_system`=0) to it faults with `fault_kind`=3. System-mode accesses are allowed.
- R6: When several violations apply, `fault_kind` reports only one of them, in this priority: system-only (3), then read-only (2), then limit (1).
- R7: A request whose segment belongs to the other unit gives `pa_valid`=0 and `fault`=0 in the next cycle.
- R8: `fault` and `pa_valid` are never both 1. While `pa_valid` is 0, `pa` is 0. While `fault` is 0, `fault_kind` is 0. A cycle with no request gives both flags 0 in the next cycle.
- R9: A descriptor write to index `wr_idx` (the low 6 bits of the segment number) takes effect for requests presented in later cycles. A request in the same cycle as the write still sees the old descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 6 | Descriptor index to write |
| wr_base | input | 16 | Base field, in 256-byte units |
| wr_limit | input | 8 | Limit field, the highest allowed offset upper byte |
| wr_attr | input | 8 | Attributes: bit 0 read-only, bit 1 system-only |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 7 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_write | input | 1 | 1 for a write access |
| req_system | input | 1 | 1 for a system-mode access |
| pa_valid | output | 1 | Translated address valid |
| pa | output | 24 | Physical address |
| fault | output | 1 | Protection or limit violation |
| fault_kind | output | 2 | 0 none, 1 limit, 2 read-only, 3 system-only |

## Verification
The bench first fills the table with random descriptors. It then drives random lookups in which the segment, offset, access kind and mode all vary. These show whether the base shift, the addition with wrap and the attribute decoding are correct. Directed cases target the following:

- offsets one block below, at and one block above the limit, which separate a strict comparison from an inclusive one;
- a base and offset pair that wraps past 2^24;
- descriptors that break several rules at once, which expose the fault priority;
- segment numbers from the other half of the space, and idle cycles;
- a lookup in the same cycle as a write to the same descriptor, which must see the old contents.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_LIMIT   = 2'd1,
        FK_RDONLY  = 2'd2,
        FK_SYSONLY = 2'd3
    } fault_kind_e;

    localparam int ATTR_RDONLY_BIT  = 0;
    localparam int ATTR_SYSONLY_BIT = 1;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int N_DESC = 64,
    parameter int IDX_W  = 6,
    parameter int BASE_W = 16,
    parameter int LIM_W  = 8,
    parameter int ATTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [ATTR_W-1:0] rd_attr
);
    localparam int ENT_W = BASE_W + LIM_W + ATTR_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [ATTR_W-1:0] attr;
    } desc_t;

    desc_t tbl_d [N_DESC];
    desc_t tbl_q [N_DESC];

    always_comb begin
        for (int i = 0; i < N_DESC; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (int'(wr_idx) == i)) begin
                tbl_d[i].base  = wr_base;
                tbl_d[i].limit = wr_limit;
                tbl_d[i].attr  = wr_attr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_DESC; i++) tbl_q[i] <= desc_t'({ENT_W{1'b0}});
        end else begin
            for (int i = 0; i < N_DESC; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    desc_t rd_ent;
    always_comb begin
        rd_ent = desc_t'({ENT_W{1'b0}});
        if (int'(rd_idx) < N_DESC) rd_ent = tbl_q[rd_idx];
    end

    assign rd_base  = rd_ent.base;
    assign rd_limit = rd_ent.limit;
    assign rd_attr  = rd_ent.attr;
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int PA_W   = 24,
    parameter int BASE_W = 16,
    parameter int LIM_W  = 8,
    parameter int ATTR_W = 8
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              is_write,
    input  logic              is_system,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [ATTR_W-1:0] attr,
    output fault_kind_e       kind,
    output logic [PA_W-1:0]   addr
);
    localparam int SHIFT = PA_W - BASE_W;

    logic [LIM_W-1:0] off_blk;
    logic             over_limit;
    logic             rd_only_hit;
    logic             sys_only_hit;

    assign off_blk      = off[OFF_W-1 -: LIM_W];
    assign over_limit   = off_blk > limit;
    assign rd_only_hit  = attr[ATTR_RDONLY_BIT] && is_write;
    assign sys_only_hit = attr[ATTR_SYSONLY_BIT] && !is_system;

    always_comb begin
        if (sys_only_hit)      kind = FK_SYSONLY;
        else if (rd_only_hit)  kind = FK_RDONLY;
        else if (over_limit)   kind = FK_LIMIT;
        else                   kind = FK_NONE;
    end

    assign addr = {base, {SHIFT{1'b0}}} + PA_W'(off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W    = 7,
    parameter int OFF_W    = 16,
    parameter int PA_W     = 24,
    parameter int N_DESC   = 64,
    parameter int BASE_W   = 16,
    parameter int LIM_W    = 8,
    parameter int ATTR_W   = 8,
    parameter int UNIT_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [$clog2(N_DESC)-1:0] wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic              req_system,
    output logic              pa_valid,
    output logic [PA_W-1:0]   pa,
    output logic              fault,
    output logic [1:0]        fault_kind
);
    localparam int IDX_W = $clog2(N_DESC);
    localparam int SEL_W = (SEG_W > IDX_W) ? SEG_W - IDX_W : 1;

    typedef struct packed {
        logic            pa_valid;
        logic [PA_W-1:0] pa;
        logic            fault;
        logic [1:0]      kind;
    } out_t;

    out_t r_d, r_q;

    logic [BASE_W-1:0] d_base;
    logic [LIM_W-1:0]  d_limit;
    logic [ATTR_W-1:0] d_attr;
    fault_kind_e       chk_kind;
    logic [PA_W-1:0]   chk_addr;
    logic              selected;

    seg_desc_table #(
        .N_DESC(N_DESC), .IDX_W(IDX_W), .BASE_W(BASE_W),
        .LIM_W(LIM_W), .ATTR_W(ATTR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_attr(wr_attr),
        .rd_idx(req_seg[IDX_W-1:0]),
        .rd_base(d_base), .rd_limit(d_limit), .rd_attr(d_attr)
    );

    seg_check #(
        .OFF_W(OFF_W), .PA_W(PA_W), .BASE_W(BASE_W),
        .LIM_W(LIM_W), .ATTR_W(ATTR_W)
    ) u_check (
        .off(req_off), .is_write(req_write), .is_system(req_system),
        .base(d_base), .limit(d_limit), .attr(d_attr),
        .kind(chk_kind), .addr(chk_addr)
    );

    generate
        if (SEG_W > IDX_W) begin : g_split
            localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(UNIT_SEL);
            assign selected = (req_seg[SEG_W-1 -: SEL_W] == SEL_VAL);
        end else begin : g_full
            assign selected = 1'b1;
        end
    endgenerate

    always_comb begin
        r_d = '0;
        if (req_valid && selected) begin
            if (chk_kind != FK_NONE) begin
                r_d.fault = 1'b1;
                r_d.kind  = chk_kind;
            end else begin
                r_d.pa_valid = 1'b1;
                r_d.pa       = chk_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pa_valid   = r_q.pa_valid;
    assign pa         = r_q.pa;
    assign fault      = r_q.fault;
    assign fault_kind = r_q.kind;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W    = 7,
    parameter int PA_W     = 24,
    parameter int IDX_W    = 6,
    parameter int UNIT_SEL = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic             req_write,
    input logic             req_system,
    input logic             pa_valid,
    input logic [PA_W-1:0]  pa,
    input logic             fault,
    input logic [1:0]       fault_kind
);
    localparam int SEL_W = (SEG_W > IDX_W) ? SEG_W - IDX_W : 1;
    localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(UNIT_SEL);

    logic sel;
    assign sel = (SEG_W > IDX_W) ? (req_seg[SEG_W-1 -: SEL_W] == SEL_VAL) : 1'b1;

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && pa_valid));

    assert_pa_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_valid |-> (pa == '0));

    assert_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind != 2'd0) == fault);

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!pa_valid && !fault));

    assert_other_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel) |=> (!pa_valid && !fault));

    assert_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel) |=> (pa_valid || fault));

    assert_sys_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel && req_system && !req_write) |=> (!fault || fault_kind == 2'd1));
endmodule

bind seg_xlate seg_xlate_chk #(
    .SEG_W(SEG_W), .PA_W(PA_W), .IDX_W($clog2(N_DESC)), .UNIT_SEL(UNIT_SEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_write(req_write), .req_system(req_system),
    .pa_valid(pa_valid), .pa(pa), .fault(fault), .fault_kind(fault_kind)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [7:0]  wr_limit = '0;
    logic [7:0]  wr_attr = '0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        req_system = 1'b0;
    logic        pa_valid;
    logic [23:0] pa;
    logic        fault;
    logic [1:0]  fault_kind;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m_base [64];
    logic [7:0]  m_limit [64];
    logic [7:0]  m_attr [64];

    always #5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_attr(wr_attr),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_write(req_write), .req_system(req_system),
        .pa_valid(pa_valid), .pa(pa), .fault(fault), .fault_kind(fault_kind)
    );

    // expected result packed as {pa_valid, pa, fault, kind}
    function automatic logic [27:0] expect_of(input logic rv, input logic [6:0] s,
                                              input logic [15:0] o, input logic w,
                                              input logic sys);
        logic [5:0] i;
        logic [1:0] k;
        i = s[5:0];
        if (!rv || s[6] != 1'b0) return 28'd0;
        if (m_attr[i][1] && !sys)        k = 2'd3;
        else if (m_attr[i][0] && w)      k = 2'd2;
        else if (o[15:8] > m_limit[i])   k = 2'd1;
        else                             k = 2'd0;
        if (k != 2'd0) return {1'b0, 24'd0, 1'b1, k};
        return {1'b1, {m_base[i], 8'd0} + {8'd0, o}, 1'b0, 2'd0};
    endfunction

    // called at a negedge; drives one cycle and checks at the next negedge
    task automatic cyc(input string tag, input logic we, input logic [5:0] wi,
                       input logic [15:0] wb, input logic [7:0] wl, input logic [7:0] wa,
                       input logic rv, input logic [6:0] s, input logic [15:0] o,
                       input logic w, input logic sys);
        logic [27:0] e;
        logic [27:0] got;
        wr_en = we; wr_idx = wi; wr_base = wb; wr_limit = wl; wr_attr = wa;
        req_valid = rv; req_seg = s; req_off = o; req_write = w; req_system = sys;
        e = expect_of(rv, s, o, w, sys);
        if (we) begin
            m_base[wi] = wb; m_limit[wi] = wl; m_attr[wi] = wa;
        end
        @(negedge clk);
        got = {pa_valid, pa, fault, fault_kind};
        n_checks++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b pa=%06h fault=%0b kind=%0d expected valid=%0b pa=%06h fault=%0b kind=%0d",
                     tag, got[27], got[26:3], got[2], got[1:0], e[27], e[26:3], e[2], e[1:0]);
        end
    endtask

    task automatic wr(input logic [5:0] i, input logic [15:0] b, input logic [7:0] l,
                      input logic [7:0] a);
        cyc("R9 write", 1'b1, i, b, l, a, 1'b0, 7'd0, 16'd0, 1'b0, 1'b0);
    endtask

    task automatic rq(input string tag, input logic [6:0] s, input logic [15:0] o,
                      input logic w, input logic sys);
        cyc(tag, 1'b0, 6'd0, 16'd0, 8'd0, 8'd0, 1'b1, s, o, w, sys);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        n_checks++;
        if ({pa_valid, pa, fault, fault_kind} !== 28'd0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: got %07h expected 0", {pa_valid, pa, fault, fault_kind});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zeroed descriptors
        rq("R1 zero desc read", 7'd5, 16'h00ff, 1'b0, 1'b0);
        rq("R1 zero desc over limit", 7'd5, 16'h0100, 1'b1, 1'b0);

        // R2 translation and wrap
        wr(6'd1, 16'h1234, 8'hff, 8'h00);
        rq("R2 basic", 7'd1, 16'habcd, 1'b1, 1'b0);
        wr(6'd2, 16'hffff, 8'hff, 8'h00);
        rq("R2 wrap", 7'd2, 16'hffff, 1'b0, 1'b1);

        // R3 limit boundary
        wr(6'd3, 16'h0040, 8'h10, 8'h00);
        rq("R3 below limit", 7'd3, 16'h0fff, 1'b0, 1'b0);
        rq("R3 at limit", 7'd3, 16'h10ff, 1'b0, 1'b0);
        rq("R3 over limit", 7'd3, 16'h1100, 1'b0, 1'b0);

        // R4 read-only
        wr(6'd4, 16'h0100, 8'hff, 8'h01);
        rq("R4 read ok", 7'd4, 16'h0010, 1'b0, 1'b0);
        rq("R4 write fault", 7'd4, 16'h0010, 1'b1, 1'b1);

        // R5 system-only
        wr(6'd6, 16'h0200, 8'hff, 8'h02);
        rq("R5 normal fault", 7'd6, 16'h0020, 1'b0, 1'b0);
        rq("R5 system ok", 7'd6, 16'h0020, 1'b1, 1'b1);

        // R6 priority
        wr(6'd7, 16'h0300, 8'h00, 8'h03);
        rq("R6 all three", 7'd7, 16'hff00, 1'b1, 1'b0);
        rq("R6 ro over limit", 7'd7, 16'hff00, 1'b1, 1'b1);
        rq("R6 limit only", 7'd7, 16'hff00, 1'b0, 1'b1);

        // R7 other unit, R8 idle
        rq("R7 other unit", 7'd65, 16'h0000, 1'b0, 1'b1);
        rq("R7 other unit bad", 7'd71, 16'hff00, 1'b1, 1'b0);
        cyc("R8 idle", 1'b0, 6'd0, 16'd0, 8'd0, 8'd0, 1'b0, 7'd1, 16'd0, 1'b0, 1'b0);

        // R9 same-cycle write and lookup sees old contents, then new
        cyc("R9 same cycle old", 1'b1, 6'd1, 16'h0abc, 8'h00, 8'h02,
            1'b1, 7'd1, 16'h0100, 1'b0, 1'b0);
        rq("R9 new desc", 7'd1, 16'h0100, 1'b0, 1'b0);

        // random fill, then mixed random traffic
        for (int i = 0; i < 64; i++)
            wr(6'(i), 16'($urandom), 8'($urandom), 8'($urandom));
        for (int n = 0; n < 4000; n++) begin
            logic we;
            we = ($urandom % 8) == 0;
            cyc("R2 random", we, 6'($urandom), 16'($urandom), 8'($urandom),
                8'($urandom & 32'h3), ($urandom % 5) != 0, 7'($urandom),
                16'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule